// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block sends frames that software has placed in memory and described in a ring of transmit descriptors. Each descriptor is four 32-bit words: a status word at offset 0, a tag word at offset 4, the low buffer address at offset 8 and the high buffer address at offset 12. Only the status word and the low buffer address are used. Descriptor `i` sits at `base + 16*i`. Software loads the ring base and then rings a doorbell. The block then walks the ring from its current index. For every descriptor whose owner flag is set, it streams the buffer bytes out on a valid/ready byte stream. It then writes the status word back with the owner flag cleared and raises a sticky completion flag. It stops at the first descriptor it does not own.

The block has one memory port that carries one word per transfer. Each request is held until an acknowledge arrives, and read data is taken in the acknowledge cycle. It also has a small register write port with combinational readback and an 8-bit output stream. The stream carries no framing, no checksum and no tag insertion. All of these are left to the stage that follows.

Top module: `txring_fetch`

## Requirements
- R1: After reset, `mem_req` and `out_valid` are low, and both the base register (address 0) and the status register (address 2) read as zero.
- R2: The base register (address 0) keeps bits 31:8 of the written value and reads bits 7:0 as zero. A base write while the block is idle sets the current descriptor index to 0.
- R3: A write to the doorbell register (address 1) starts a scan only if bit 6 of the written data is 1. Other doorbell writes are ignored. A doorbell that arrives during a scan is held, and a second scan starts from the current index once the first scan stops.
- R4: The status word of descriptor `i` is read at `base + 16*i` and the buffer address at `base + 16*i + 8`. The words at offsets 4 and 12 are never accessed.
- R5: If bit 31 (owner) of the status word that was read is 0, the scan stops. Nothing is streamed and nothing is written for that descriptor.
- R6: For an owned descriptor, the block streams exactly `status[12:0]` bytes, starting at the buffer address, which may be any byte address. Bytes are taken little-endian from 32-bit memory words (byte `k` of a word is bits `8k+7:8k`). While `out_ready` is low, `out_data` and `out_last` hold steady.
- R7: After the last byte, the status word is written back unchanged except that bit 31 is cleared. Status register bit 0 (done) is then set.
- R8: After a descriptor is handled, the index wraps to 0 if bit 30 (end of ring) of its status was set, and otherwise increments. The scan then continues with the next descriptor.
- R9: `out_last` is high on the final byte of a descriptor only when bit 28 (last segment) of its status is set. It is low on every other byte.
- R10: An owned descriptor with a length field of 0 streams nothing. It still has its owner bit cleared in memory, and it sets status bit 1 (error) instead of bit 0.
- R11: Status bits are sticky. Writing 1 to a bit at address 2 clears it, and writing 0 leaves it unchanged.
- R12: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 base, 1 doorbell, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the addressed register |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a last-segment descriptor |
| out_ready | input | 1 | Stream sink accepts the byte |

## Verification
The ring is exercised with descriptors that have odd lengths and buffers starting at every byte offset within a word, so word refills at different byte lanes are separated from aligned runs. Back pressure comes in three patterns: random ready, fully stalled and always ready. Memory acknowledges arrive after random delays. Together these separate correct holding behaviour from behaviour that merely matches the default timing. Directed rings cover several stop and wrap cases: a stop at an unowned descriptor, a wrap through the end-of-ring flag back to a re-armed first entry, a zero-length entry, a segment without the last flag, an ignored doorbell and a doorbell queued mid-scan. The queued doorbell is distinguished from a lost one by counting reads of the stopping descriptor. Randomized four-entry rings then compare the full byte stream and the owner write-backs against values the bench builds from its own memory image.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W = 32;
  localparam int RA_W   = 2;

  localparam logic [RA_W-1:0] RA_BASE = 2'd0;
  localparam logic [RA_W-1:0] RA_POLL = 2'd1;
  localparam logic [RA_W-1:0] RA_STAT = 2'd2;

  localparam int OWN_BIT  = 31;
  localparam int EOR_BIT  = 30;
  localparam int LS_BIT   = 28;
  localparam int POLL_BIT = 6;
  localparam int STS_DONE = 0;
  localparam int STS_ERR  = 1;
  localparam int BASE_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STAT  = 3'd1,
    ST_BUFA  = 3'd2,
    ST_WORD  = 3'd3,
    ST_SEND  = 3'd4,
    ST_WBACK = 3'd5
  } eng_st_e;
endpackage

// File: rtl/txr_rst_sync.sv
module txr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [WORD_W-1:0] base_o,
  output logic              base_wr_o,
  output logic              poll_pend_o,
  input  logic              poll_take_i,
  input  logic              done_evt_i,
  input  logic              err_evt_i
);
  localparam int BASE_W = WORD_W - BASE_LSB;

  logic [BASE_W-1:0] base_q, base_d;
  logic [1:0]        sts_q, sts_d, sts_clr;
  logic              pend_q, pend_d, poll_hit;

  always_comb begin
    base_wr_o = reg_we && (reg_addr == RA_BASE);
    poll_hit  = reg_we && (reg_addr == RA_POLL) && reg_wdata[POLL_BIT];
    sts_clr   = (reg_we && (reg_addr == RA_STAT)) ? reg_wdata[1:0] : 2'b00;
    base_d    = reg_wdata[WORD_W-1:BASE_LSB];
    sts_d[STS_DONE] = done_evt_i | (sts_q[STS_DONE] & ~sts_clr[STS_DONE]);
    sts_d[STS_ERR]  = err_evt_i  | (sts_q[STS_ERR]  & ~sts_clr[STS_ERR]);
    pend_d    = poll_hit | (pend_q & ~poll_take_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sts_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (base_wr_o) base_q <= base_d;
      sts_q  <= sts_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_BASE: reg_rdata = {base_q, {BASE_LSB{1'b0}}};
      RA_STAT: reg_rdata = {{(WORD_W-2){1'b0}}, sts_q};
      default: reg_rdata = '0;
    endcase
  end

  assign base_o      = {base_q, {BASE_LSB{1'b0}}};
  assign poll_pend_o = pend_q;

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_i |=> sts_q[STS_DONE]);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> sts_q[STS_ERR]);

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !poll_take_i |=> pend_q);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base_i,
  input  logic              base_wr_i,
  input  logic              poll_pend_i,
  output logic              poll_take_o,
  output logic              done_evt_o,
  output logic              err_evt_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int                DESC_SH  = 4;
  localparam logic [WORD_W-1:0] BUFA_OFS = WORD_W'(8);

  eng_st_e           st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] stat_q, ptr_q, ptr_d, wbuf_q, desc_addr;
  logic [LEN_W-1:0]  rem_q, rem_d, len_field;
  logic              len_zero, rem_one, send_fire;
  logic              stat_en, wbuf_en, ptr_en, idx_en;

  assign desc_addr = base_i + WORD_W'({idx_q, {DESC_SH{1'b0}}});
  assign len_field = stat_q[LEN_W-1:0];
  assign len_zero  = (len_field == '0);
  assign rem_one   = (rem_q == LEN_W'(1));
  assign send_fire = (st_q == ST_SEND) && out_ready;

  assign stat_en = (st_q == ST_STAT) && mem_ack;
  assign wbuf_en = (st_q == ST_WORD) && mem_ack;
  assign ptr_en  = ((st_q == ST_BUFA) && mem_ack) || send_fire;
  assign idx_en  = ((st_q == ST_WBACK) && mem_ack) || ((st_q == ST_IDLE) && base_wr_i);

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    ptr_d       = ptr_q;
    rem_d       = rem_q;
    poll_take_o = 1'b0;
    done_evt_o  = 1'b0;
    err_evt_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (base_wr_i) idx_d = '0;
        if (poll_pend_i) begin
          poll_take_o = 1'b1;
          st_d        = ST_STAT;
        end
      end
      ST_STAT: begin
        if (mem_ack) st_d = mem_rdata[OWN_BIT] ? ST_BUFA : ST_IDLE;
      end
      ST_BUFA: begin
        if (mem_ack) begin
          ptr_d = mem_rdata;
          rem_d = len_field;
          st_d  = len_zero ? ST_WBACK : ST_WORD;
        end
      end
      ST_WORD: begin
        if (mem_ack) st_d = ST_SEND;
      end
      ST_SEND: begin
        if (out_ready) begin
          ptr_d = ptr_q + WORD_W'(1);
          rem_d = rem_q - LEN_W'(1);
          if (rem_one)                 st_d = ST_WBACK;
          else if (ptr_q[1:0] == 2'd3) st_d = ST_WORD;
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          err_evt_o  = len_zero;
          done_evt_o = !len_zero;
          idx_d      = stat_q[EOR_BIT] ? '0 : idx_q + IDX_W'(1);
          st_d       = ST_STAT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      stat_q <= '0;
      ptr_q  <= '0;
      rem_q  <= '0;
      wbuf_q <= '0;
    end else begin
      st_q <= st_d;
      if (idx_en)  idx_q  <= idx_d;
      if (stat_en) stat_q <= mem_rdata;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (ptr_en)  rem_q  <= rem_d;
      if (wbuf_en) wbuf_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_req   = (st_q == ST_STAT) || (st_q == ST_BUFA) ||
                (st_q == ST_WORD) || (st_q == ST_WBACK);
    mem_we    = (st_q == ST_WBACK);
    mem_wdata = stat_q & ~(WORD_W'(1) << OWN_BIT);
    unique case (st_q)
      ST_BUFA: mem_addr = desc_addr + BUFA_OFS;
      ST_WORD: mem_addr = {ptr_q[WORD_W-1:2], 2'b00};
      default: mem_addr = desc_addr;
    endcase
    out_valid = (st_q == ST_SEND);
    out_data  = wbuf_q[{ptr_q[1:0], 3'b000} +: 8];
    out_last  = (st_q == ST_SEND) && rem_one && stat_q[LS_BIT];
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R7
  wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

  // R4
  no_tag_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (st_q != ST_WORD) |-> !mem_addr[2]);

  // R10
  err_no_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_o |-> !out_valid && $past(!out_valid));
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
  import txr_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] base;
  logic              base_wr, poll_pend, poll_take, done_evt, err_evt;

  txr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  txr_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_o(base), .base_wr_o(base_wr), .poll_pend_o(poll_pend), .poll_take_i(poll_take),
    .done_evt_i(done_evt), .err_evt_i(err_evt)
  );

  txr_engine #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_n),
    .base_i(base), .base_wr_i(base_wr), .poll_pend_i(poll_pend), .poll_take_o(poll_take),
    .done_evt_o(done_evt), .err_evt_o(err_evt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );
endmodule

// File: tb/txring_fetch_bench.sv
module txring_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_last, out_ready;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  txring_fetch u_txring_fetch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  logic [31:0] mem [0:1023];
  logic [7:0]  exp_b [0:2047];
  logic        exp_l [0:2047];
  logic [7:0]  cap_b [0:2047];
  logic        cap_l [0:2047];
  int exp_n, cap_n, checks, fails;
  int ready_mode, watch_cnt, bad_acc, hold_err;
  logic [31:0] watch_addr, ring_lo, ring_hi, prev_addr;
  logic        pend_prev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  function automatic logic [31:0] mk_stat(input bit own, input bit eor, input bit ls, input int len);
    return ({31'd0, own} << 31) | ({31'd0, eor} << 30) | (32'd1 << 29) |
           ({31'd0, ls} << 28) | (32'(len) & 32'h1FFF);
  endfunction

  task automatic set_desc(input logic [31:0] base, input int idx, input bit own, input bit eor,
                          input bit ls, input int len, input logic [31:0] bufa);
    logic [31:0] da, a;
    logic [7:0]  b;
    da = base + 32'(idx * 16);
    mem[da[11:2]]          = mk_stat(own, eor, ls, len);
    mem[(da + 32'd4) >> 2]  = 32'hA5A5_0000 | 32'(idx);
    mem[(da + 32'd8) >> 2]  = bufa;
    mem[(da + 32'd12) >> 2] = 32'h0;
    for (int i = 0; i < len; i++) begin
      a = bufa + 32'(i);
      b = 8'($urandom);
      mem[a[11:2]][a[1:0]*8 +: 8] = b;
      if (own) begin
        exp_b[exp_n] = b;
        exp_l[exp_n] = ls && (i == len - 1);
        exp_n++;
      end
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while (cap_n < exp_n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) chk({tag, " stream timeout"}, 32'(cap_n), 32'(exp_n));
    repeat (80) @(negedge clk);
  endtask

  task automatic check_stream(input string tag);
    int bad;
    bad = -1;
    chk({tag, " byte count"}, 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && (cap_b[i] !== exp_b[i] || cap_l[i] !== exp_l[i])) bad = i;
    if (bad >= 0) chk({tag, " data/last"}, {23'd0, cap_l[bad], cap_b[bad]}, {23'd0, exp_l[bad], exp_b[bad]});
    else          chk({tag, " data/last"}, 32'd0, 32'd0);
    cap_n = 0;
    exp_n = 0;
  endtask

  // stream sink: ready pattern, then capture of the handshake at the next edge
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      case (ready_mode)
        1:       out_ready = 1'b0;
        2:       out_ready = 1'b1;
        default: out_ready = ($urandom % 4) != 0;
      endcase
      #1;
      if (out_valid && out_ready && cap_n < 2048) begin
        cap_b[cap_n] = out_data;
        cap_l[cap_n] = out_last;
        cap_n++;
      end
    end
  end

  // memory model with random acknowledge delay
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; pend_prev = 1'b0; prev_addr = '0;
    forever begin
      @(negedge clk);
      #2;
      if (pend_prev && !(mem_req && mem_addr == prev_addr)) hold_err++;
      if (mem_req && ($urandom % 3) != 0) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[11:2]];
        if (!mem_we && mem_addr == watch_addr) watch_cnt++;
        if (mem_addr >= ring_lo && mem_addr < ring_hi && mem_addr[2]) bad_acc++;
        pend_prev = 1'b0;
      end else begin
        mem_ack   = 1'b0;
        pend_prev = mem_req;
        prev_addr = mem_addr;
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, s0, s1, s2, s3;
    logic [31:0] B, R;
    int t;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    checks = 0; fails = 0; exp_n = 0; cap_n = 0;
    ready_mode = 0; watch_cnt = 0; bad_acc = 0; hold_err = 0;
    watch_addr = 32'hFFFF_FFF0; B = 32'h100; ring_lo = B; ring_hi = B + 32'h100;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    reg_read(2'd2, rd); chk("R1 status", rd, 32'd0);
    reg_read(2'd0, rd); chk("R1 base", rd, 32'd0);

    // R2 base readback masks low byte
    reg_write(2'd0, 32'h0001_2345);
    reg_read(2'd0, rd); chk("R2 base low byte", rd, 32'h0001_2300);
    reg_write(2'd0, B);

    // R6 R9 R7 R8: two owned descriptors, odd offset, stop at third
    set_desc(B, 0, 1, 0, 1, 5, 32'h403);
    set_desc(B, 1, 1, 0, 1, 8, 32'h420);
    set_desc(B, 2, 0, 0, 1, 4, 32'h440);
    s0 = mrd(B); s1 = mrd(B + 32'h10); s2 = mrd(B + 32'h20);
    reg_write(2'd1, 32'h40);
    wait_done("R6 first ring");
    check_stream("R6 R9 first ring");
    chk("R7 owner cleared d0", mrd(B), s0 & 32'h7FFF_FFFF);
    chk("R7 owner cleared d1", mrd(B + 32'h10), s1 & 32'h7FFF_FFFF);
    reg_read(2'd2, rd); chk("R7 done status", rd, 32'd1);

    // R11 write 0 keeps, write 1 clears
    reg_write(2'd2, 32'd0);
    reg_read(2'd2, rd); chk("R11 write zero keeps", rd, 32'd1);
    reg_write(2'd2, 32'd1);
    reg_read(2'd2, rd); chk("R11 w1c clears", rd, 32'd0);

    // R5 unowned descriptor: nothing happens
    reg_write(2'd1, 32'h40);
    repeat (60) @(negedge clk);
    chk("R5 no bytes", 32'(cap_n), 32'd0);
    chk("R5 desc untouched", mrd(B + 32'h20), s2);
    reg_read(2'd2, rd); chk("R5 status unchanged", rd, 32'd0);

    // R3 doorbell without bit 6 ignored
    set_desc(B, 2, 1, 1, 1, 4, 32'h440);
    reg_write(2'd1, 32'hBF);
    repeat (60) @(negedge clk);
    chk("R3 ignored doorbell", 32'(cap_n), 32'd0);
    reg_write(2'd1, 32'h40);
    wait_done("R8 eor entry");
    check_stream("R8 end-of-ring entry");

    // R8 wrap to index 0, R9 segment without last flag
    set_desc(B, 0, 1, 0, 0, 3, 32'h462);
    reg_write(2'd1, 32'h40);
    wait_done("R8 wrap");
    check_stream("R8 R9 wrapped entry no last");

    // R10 zero length
    reg_write(2'd2, 32'd3);
    set_desc(B, 1, 1, 0, 1, 0, 32'h480);
    s1 = mrd(B + 32'h10);
    reg_write(2'd1, 32'h40);
    repeat (100) @(negedge clk);
    chk("R10 no bytes", 32'(cap_n), 32'd0);
    chk("R10 owner cleared", mrd(B + 32'h10), s1 & 32'h7FFF_FFFF);
    reg_read(2'd2, rd); chk("R10 error status", rd, 32'd2);

    // R3 doorbell queued during a scan
    set_desc(B, 2, 1, 0, 1, 20, 32'h4A1);
    watch_addr = B + 32'h30; watch_cnt = 0;
    ready_mode = 1;
    reg_write(2'd1, 32'h40);
    t = 0;
    while (!out_valid && t < 500) begin @(negedge clk); t++; end
    reg_write(2'd1, 32'h40);
    ready_mode = 0;
    wait_done("R3 queued");
    check_stream("R3 queued scan stream");
    chk("R3 second scan reads stop entry again", 32'(watch_cnt), 32'd2);
    watch_addr = 32'hFFFF_FFF0;

    // random rings, base write resets index (R2)
    for (int r = 0; r < 3; r++) begin
      R = 32'h600;
      ring_lo = R; ring_hi = R + 32'h100;
      ready_mode = (r == 2) ? 2 : 0;
      reg_write(2'd2, 32'd3);
      reg_write(2'd0, R | 32'($urandom % 256));
      for (int i = 0; i < 4; i++)
        set_desc(R, i, 1, i == 3, ($urandom % 2) == 1, 1 + int'($urandom % 60),
                 32'h800 + 32'(i * 128) + 32'($urandom % 4));
      s0 = mrd(R); s1 = mrd(R + 32'h10); s2 = mrd(R + 32'h20); s3 = mrd(R + 32'h30);
      reg_write(2'd1, 32'h40);
      wait_done("R2 random ring");
      check_stream("R2 R6 random ring");
      chk("R7 random owners", {mrd(R)[31], mrd(R + 32'h10)[31], mrd(R + 32'h20)[31], mrd(R + 32'h30)[31]}, 32'd0);
      chk("R7 random wb body", mrd(R + 32'h30), s3 & 32'h7FFF_FFFF);
      reg_read(2'd2, rd); chk("R7 random done", rd, 32'd1);
      if (s0 == 0 || s1 == 0 || s2 == 0) chk("setup", 32'd1, 32'd0);
    end

    chk("R4 tag/high words untouched", 32'(bad_acc), 32'd0);
    chk("R12 request held until ack", 32'(hold_err), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule